// File: doc/BRIEF.md
# Per-Pin Multiplexed GPIO Port

This block is one 32-pin general-purpose I/O port. For every pin it chooses what drives the pad and what each of two internal input buses sees. Two bits per pin pick the driver at the first level. One bit hands the pin to the port's own GPIO logic. The other bit chooses between the primary and the alternate peripheral when the GPIO logic does not own the pin. A pin in GPIO mode then reads a 2-bit output field. That field picks the pad driver from three internal sources and the port data register.

Each pin also carries two 2-bit input fields, one for internal bus A and one for internal bus B. Each field sends that bus one of four values: the synchronized pad level, the pin's interrupt status, a constant 0 or a constant 1. Each 2-bit field is spread over a pair of registers. Pins 0 to 15 are in the low register and pins 16 to 31 are in the high register. A separate register drives one pull-up enable line per pin.

Software reaches the registers through a word-wide bus. Several ports share one address window, and each port takes a 64-word slice of it. A read returns the whole register, so software can change one pin's field with a read-modify-write.

Top module: `pinmux_port`

## Requirements
- R1: After reset every register reads 0, every pad follows its primary input (`pad_out == pri_out`) and `pullup_en` is 0.
- R2: A pin whose GPIO-own bit (word 0) is 0 and whose alternate bit (word 1) is 0 drives `pri_out` of that pin on its pad.
- R3: A pin whose GPIO-own bit is 0 and whose alternate bit is 1 drives `alt_out`. When the GPIO-own bit is 1, the alternate bit has no effect.
- R4: A pin whose GPIO-own bit is 1 drives its pad from its output field. The codes are 0 for `src_a`, 1 for `src_b`, 2 for `src_c` and 3 for the data register (word 2).
- R5: The output field sits in words 3 (low) and 4 (high). Input field A sits in words 5 and 6, and input field B in words 7 and 8. Pin p < 16 uses bits [2p+1:2p] of the low word. Pin p >= 16 uses bits [2(p-16)+1:2(p-16)] of the high word.
- R6: For each input field, code 0 passes the synchronized pad value, code 1 passes `irq_stat`, code 2 gives 0 and code 3 gives 1. Field A drives `bus_a_out` and field B drives `bus_b_out`, independently per pin.
- R7: Pad inputs go through two flops. A change on `pad_in` reaches `bus_a_out`, `bus_b_out` and read-only word 10 after two rising edges, and not after one.
- R8: Word 9 drives `pullup_en` bit for bit.
- R9: A read returns the full addressed register. Writing one word leaves every other word unchanged. A bus access is for this port only when `bus_addr[8:6]` equals `PORT_ID`. An access to another port, or to a word above 10, reads 0 and changes nothing. Writes to word 10 are ignored.
- R10: A write with `bus_sel` and `bus_we` high takes effect at the next rising edge. With `bus_sel` low, nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 9 | {port[2:0], word[5:0]} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_in | input | 32 | Pad levels, asynchronous |
| pad_out | output | 32 | Pad drive values |
| pri_out | input | 32 | Primary peripheral outputs |
| alt_out | input | 32 | Alternate peripheral outputs |
| src_a | input | 32 | Internal output source A |
| src_b | input | 32 | Internal output source B |
| src_c | input | 32 | Internal output source C |
| irq_stat | input | 32 | Per-pin interrupt status |
| bus_a_out | output | 32 | Internal input bus A |
| bus_b_out | output | 32 | Internal input bus B |
| pullup_en | output | 32 | Pull-up enable per pin |

## Verification
The bench places distinct codes on pins on both sides of the 15/16 boundary, in both the low and the high word. A design that shifted the high-word index the wrong way would drive pins above 15 from the wrong field. The bench checks that the alternate bit is ignored once a pin is in GPIO mode, which catches a mux that gives the peripherals priority. It checks the pad path one edge after a change and again after the second edge, which catches a synchronizer that is one stage short or one stage long. It also checks that writes to another port's slice, to the read-only word and with the strobe low leave the registers unchanged, which catches a decode that ignores the port bits.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  localparam int unsigned WIDX_W = 6;
  localparam int unsigned NUM_RW = 10;

  typedef enum logic [WIDX_W-1:0] {
    RI_OWN     = 6'd0,
    RI_ALT     = 6'd1,
    RI_DOUT    = 6'd2,
    RI_OCFG_LO = 6'd3,
    RI_OCFG_HI = 6'd4,
    RI_ICA_LO  = 6'd5,
    RI_ICA_HI  = 6'd6,
    RI_ICB_LO  = 6'd7,
    RI_ICB_HI  = 6'd8,
    RI_PULL    = 6'd9,
    RI_PAD     = 6'd10
  } reg_idx_e;

  typedef enum logic [1:0] {
    OSRC_A    = 2'd0,
    OSRC_B    = 2'd1,
    OSRC_C    = 2'd2,
    OSRC_DATA = 2'd3
  } out_src_e;

  typedef enum logic [1:0] {
    IN_PAD  = 2'd0,
    IN_IRQ  = 2'd1,
    IN_LOW  = 2'd2,
    IN_HIGH = 2'd3
  } in_src_e;

  // {high word, low word}: pin p sits at bits 2p+1:2p of the pair
  function automatic logic [1:0] field_of(input logic [63:0] pair, input int unsigned pin);
    return pair[2*pin +: 2];
  endfunction

  function automatic logic out_pick(input logic [1:0] code, input logic a, input logic b,
                                    input logic c, input logic d);
    case (out_src_e'(code))
      OSRC_A:  return a;
      OSRC_B:  return b;
      OSRC_C:  return c;
      default: return d;
    endcase
  endfunction

  function automatic logic in_pick(input logic [1:0] code, input logic pad, input logic irq);
    case (in_src_e'(code))
      IN_PAD:  return pad;
      IN_IRQ:  return irq;
      IN_LOW:  return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int unsigned PINS      = 32,
  parameter int unsigned PORT_ID   = 0,
  parameter int unsigned PORT_BITS = 3,
  localparam int unsigned ADDR_W   = PORT_BITS + WIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_sync,
  output logic [PINS-1:0]   own_q,
  output logic [PINS-1:0]   alt_q,
  output logic [PINS-1:0]   dout_q,
  output logic [PINS-1:0]   ocfg_lo,
  output logic [PINS-1:0]   ocfg_hi,
  output logic [PINS-1:0]   ica_lo,
  output logic [PINS-1:0]   ica_hi,
  output logic [PINS-1:0]   icb_lo,
  output logic [PINS-1:0]   icb_hi,
  output logic [PINS-1:0]   pull_q,
  output logic              wr_hit,
  output logic [WIDX_W-1:0] wr_idx
);
  logic              port_hit;
  logic [WIDX_W-1:0] widx;
  logic [PINS-1:0]   rf [NUM_RW];

  assign widx     = bus_addr[WIDX_W-1:0];
  assign port_hit = (bus_addr[ADDR_W-1:WIDX_W] == PORT_BITS'(PORT_ID));
  assign wr_hit   = bus_sel && bus_we && port_hit && (widx < WIDX_W'(NUM_RW));
  assign wr_idx   = widx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NUM_RW); i++) rf[i] <= '0;
    end else if (wr_hit) begin
      for (int i = 0; i < int'(NUM_RW); i++)
        if (widx == WIDX_W'(i)) rf[i] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && port_hit) begin
      for (int i = 0; i < int'(NUM_RW); i++)
        if (widx == WIDX_W'(i)) bus_rdata = rf[i];
      if (widx == RI_PAD) bus_rdata = pad_sync;
    end
  end

  assign own_q   = rf[RI_OWN];
  assign alt_q   = rf[RI_ALT];
  assign dout_q  = rf[RI_DOUT];
  assign ocfg_lo = rf[RI_OCFG_LO];
  assign ocfg_hi = rf[RI_OCFG_HI];
  assign ica_lo  = rf[RI_ICA_LO];
  assign ica_hi  = rf[RI_ICA_HI];
  assign icb_lo  = rf[RI_ICB_LO];
  assign icb_hi  = rf[RI_ICB_HI];
  assign pull_q  = rf[RI_PULL];
endmodule

// File: rtl/pinmux_lane.sv
module pinmux_lane
  import pinmux_pkg::*;
(
  input  logic       own,
  input  logic       alt,
  input  logic [1:0] ocfg,
  input  logic [1:0] ica,
  input  logic [1:0] icb,
  input  logic       pri_in,
  input  logic       alt_in,
  input  logic       a_in,
  input  logic       b_in,
  input  logic       c_in,
  input  logic       data_in,
  input  logic       pad_s,
  input  logic       irq,
  output logic       pad_o,
  output logic       bus_a,
  output logic       bus_b
);
  logic gpio_drv;

  assign gpio_drv = out_pick(ocfg, a_in, b_in, c_in, data_in);

  always_comb begin
    if (own)      pad_o = gpio_drv;
    else if (alt) pad_o = alt_in;
    else          pad_o = pri_in;
  end

  assign bus_a = in_pick(ica, pad_s, irq);
  assign bus_b = in_pick(icb, pad_s, irq);
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
  import pinmux_pkg::*;
#(
  parameter int unsigned PINS      = 32,
  parameter int unsigned PORT_ID   = 0,
  parameter int unsigned PORT_BITS = 3,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_we,
  input  logic [PORT_BITS+WIDX_W-1:0]   bus_addr,
  input  logic [PINS-1:0]               bus_wdata,
  output logic [PINS-1:0]               bus_rdata,
  input  logic [PINS-1:0]               pad_in,
  output logic [PINS-1:0]               pad_out,
  input  logic [PINS-1:0]               pri_out,
  input  logic [PINS-1:0]               alt_out,
  input  logic [PINS-1:0]               src_a,
  input  logic [PINS-1:0]               src_b,
  input  logic [PINS-1:0]               src_c,
  input  logic [PINS-1:0]               irq_stat,
  output logic [PINS-1:0]               bus_a_out,
  output logic [PINS-1:0]               bus_b_out,
  output logic [PINS-1:0]               pullup_en
);
  localparam int unsigned PAIR_W = 2 * PINS;

  logic [PINS-1:0]   pad_sync;
  logic [PINS-1:0]   own_q, alt_q, dout_q;
  logic [PINS-1:0]   ocfg_lo, ocfg_hi, ica_lo, ica_hi, icb_lo, icb_hi;
  logic              wr_hit;
  logic [WIDX_W-1:0] wr_idx;
  logic [PAIR_W-1:0] ocfg_pair, ica_pair, icb_pair;

  pinmux_sync #(.W(PINS), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  pinmux_regs #(.PINS(PINS), .PORT_ID(PORT_ID), .PORT_BITS(PORT_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_sync(pad_sync),
    .own_q(own_q), .alt_q(alt_q), .dout_q(dout_q),
    .ocfg_lo(ocfg_lo), .ocfg_hi(ocfg_hi),
    .ica_lo(ica_lo), .ica_hi(ica_hi), .icb_lo(icb_lo), .icb_hi(icb_hi),
    .pull_q(pullup_en), .wr_hit(wr_hit), .wr_idx(wr_idx)
  );

  assign ocfg_pair = {ocfg_hi, ocfg_lo};
  assign ica_pair  = {ica_hi, ica_lo};
  assign icb_pair  = {icb_hi, icb_lo};

  for (genvar p = 0; p < int'(PINS); p++) begin : g_lane
    pinmux_lane u_lane (
      .own(own_q[p]), .alt(alt_q[p]),
      .ocfg(field_of(64'(ocfg_pair), p)),
      .ica(field_of(64'(ica_pair), p)),
      .icb(field_of(64'(icb_pair), p)),
      .pri_in(pri_out[p]), .alt_in(alt_out[p]),
      .a_in(src_a[p]), .b_in(src_b[p]), .c_in(src_c[p]), .data_in(dout_q[p]),
      .pad_s(pad_sync[p]), .irq(irq_stat[p]),
      .pad_o(pad_out[p]), .bus_a(bus_a_out[p]), .bus_b(bus_b_out[p])
    );
  end
endmodule

// File: rtl/pinmux_port_chk.sv
module pinmux_port_chk
  import pinmux_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PINS-1:0]   pad_in,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pri_out,
  input logic [PINS-1:0]   alt_out,
  input logic [PINS-1:0]   own_q,
  input logic [PINS-1:0]   alt_q,
  input logic [PINS-1:0]   dout_q,
  input logic [2*PINS-1:0] ocfg_pair,
  input logic [2*PINS-1:0] ica_pair,
  input logic [PINS-1:0]   bus_a_out,
  input logic [PINS-1:0]   bus_wdata,
  input logic [PINS-1:0]   pullup_en,
  input logic              wr_hit,
  input logic [WIDX_W-1:0] wr_idx
);
  logic [PINS-1:0] m_data, m_a_pad, m_a_low, m_a_high;
  logic [1:0]      since_rst;

  always_comb begin
    for (int p = 0; p < int'(PINS); p++) begin
      m_data[p]   = own_q[p] && (ocfg_pair[2*p +: 2] == 2'd3);
      m_a_pad[p]  = (ica_pair[2*p +: 2] == 2'd0);
      m_a_low[p]  = (ica_pair[2*p +: 2] == 2'd2);
      m_a_high[p] = (ica_pair[2*p +: 2] == 2'd3);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pullup_en == '0 && own_q == '0 && alt_q == '0));

  p_primary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~own_q & ~alt_q & (pad_out ^ pri_out)) == '0));

  p_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((~own_q & alt_q & (pad_out ^ alt_out)) == '0));

  p_data_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_data & (pad_out ^ dout_q)) == '0));

  p_in_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_a_low & bus_a_out) == '0) && ((m_a_high & ~bus_a_out) == '0));

  p_sync_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> ((m_a_pad & (bus_a_out ^ $past(pad_in, 2))) == '0));

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(own_q) && $stable(alt_q) && $stable(pullup_en) && $stable(dout_q)));

  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_idx == RI_PULL) |=> (pullup_en == $past(bus_wdata)));
endmodule

bind pinmux_port pinmux_port_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_out(pad_out),
  .pri_out(pri_out), .alt_out(alt_out), .own_q(own_q), .alt_q(alt_q),
  .dout_q(dout_q), .ocfg_pair(ocfg_pair), .ica_pair(ica_pair),
  .bus_a_out(bus_a_out), .bus_wdata(bus_wdata), .pullup_en(pullup_en),
  .wr_hit(wr_hit), .wr_idx(wr_idx)
);

// File: tb/pinmux_port_bench.sv
module pinmux_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pad_in = '0, pad_out, pri_out = '0, alt_out = '0;
  logic [31:0] src_a = '0, src_b = '0, src_c = '0, irq_stat = '0;
  logic [31:0] bus_a_out, bus_b_out, pullup_en;
  int checks = 0, errors = 0;
  bit done = 0;

  // word map used by the bench (R5, R9)
  localparam int W_OWN = 0, W_ALT = 1, W_DOUT = 2, W_OLO = 3, W_OHI = 4;
  localparam int W_ALO = 5, W_AHI = 6, W_BLO = 7, W_BHI = 8, W_PULL = 9, W_PAD = 10;

  logic [31:0] sh [11];

  always #5 clk = ~clk;

  pinmux_port u_pinmux_port (.*);

  function automatic logic [8:0] adr(input int port, input int word);
    return {3'(port), 6'(word)};
  endfunction

  function automatic int fld(input logic [31:0] lo, input logic [31:0] hi, input int pin);
    if (pin < 16) return int'((lo >> (pin * 2)) & 32'h3);
    return int'((hi >> ((pin - 16) * 2)) & 32'h3);
  endfunction

  function automatic logic [31:0] exp_pad();
    logic [31:0] r;
    for (int p = 0; p < 32; p++) begin
      if (!sh[W_OWN][p]) r[p] = sh[W_ALT][p] ? alt_out[p] : pri_out[p];
      else begin
        case (fld(sh[W_OLO], sh[W_OHI], p))
          0: r[p] = src_a[p];
          1: r[p] = src_b[p];
          2: r[p] = src_c[p];
          default: r[p] = sh[W_DOUT][p];
        endcase
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_in(input logic [31:0] lo, input logic [31:0] hi);
    logic [31:0] r;
    for (int p = 0; p < 32; p++) begin
      case (fld(lo, hi, p))
        0: r[p] = pad_in[p];
        1: r[p] = irq_stat[p];
        2: r[p] = 1'b0;
        default: r[p] = 1'b1;
      endcase
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int port, input int word, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = adr(port, word); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    if (port == 0 && word < 10) sh[word] = d;
  endtask

  task automatic rd(input int port, input int word, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = adr(port, word);
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int w = 0; w < 10; w++) begin
      rd(0, w, d);
      chk("R1 reg reset", d, 32'h0);
    end
    pri_out = 32'h1357_9BDF; #1;
    chk("R1 pad primary after reset", pad_out, 32'h1357_9BDF);
    chk("R1 pullup reset", pullup_en, 32'h0);
  endtask

  task automatic t_primary();
    pri_out = 32'hA5A5_0FF0; #1;
    chk("R2 primary pattern 1", pad_out, exp_pad());
    pri_out = 32'h8000_0001; #1;
    chk("R2 primary pattern 2", pad_out, exp_pad());
  endtask

  task automatic t_alt();
    pri_out = 32'hFFFF_0000; alt_out = 32'h00FF_FF00;
    wr(0, W_ALT, 32'h0F0F_3C3C); #1;
    chk("R3 alternate select", pad_out, (32'h0F0F_3C3C & alt_out) | (~32'h0F0F_3C3C & pri_out));
    src_a = 32'h1234_5678;
    wr(0, W_OWN, 32'h0000_FFFF); #1;
    chk("R3 alt ignored when gpio owns pin", pad_out, exp_pad());
    chk("R3 gpio low half from src_a", pad_out[15:0], 16'h5678);
    wr(0, W_OWN, 32'h0); wr(0, W_ALT, 32'h0);
  endtask

  task automatic t_outcfg();
    src_a = 32'h1111_1111; src_b = 32'h2222_2222; src_c = 32'h4444_4444;
    wr(0, W_DOUT, 32'h8888_8888);
    wr(0, W_OWN, 32'hFFFF_FFFF);
    // low pins 0..3 -> A,B,C,data ; high pins 16..19 -> data,C,B,A
    wr(0, W_OLO, 32'h0000_00E4);
    wr(0, W_OHI, 32'h0000_001B); #1;
    chk("R4 R5 out cfg pattern 1", pad_out, exp_pad());
    src_a = 32'hFFFF_FFFF; src_b = 32'h0; src_c = 32'h0; #1;
    chk("R5 pin16 in high word uses data", pad_out[16], 1'b0);
    chk("R5 pin19 in high word uses src_a", pad_out[19], 1'b1);
    src_a = 32'hDEAD_BEEF; src_b = 32'hCAFE_F00D; src_c = 32'h0BAD_F00D;
    wr(0, W_OLO, 32'h5A5A_C3C3);
    wr(0, W_OHI, 32'hF00F_9669); #1;
    chk("R4 R5 out cfg pattern 2", pad_out, exp_pad());
  endtask

  task automatic t_incfg();
    pad_in = 32'hC0DE_1234; irq_stat = 32'h5555_AAAA;
    repeat (3) @(negedge clk);
    wr(0, W_ALO, 32'h1B1B_E4E4);
    wr(0, W_AHI, 32'hE4E4_1B1B);
    wr(0, W_BLO, 32'hAAAA_5555);
    wr(0, W_BHI, 32'h0000_FFFF); #1;
    chk("R6 bus A cfg", bus_a_out, exp_in(sh[W_ALO], sh[W_AHI]));
    chk("R6 bus B cfg independent", bus_b_out, exp_in(sh[W_BLO], sh[W_BHI]));
    wr(0, W_ALO, 32'h0); wr(0, W_AHI, 32'h0); #1;
    chk("R6 bus A pad passthrough", bus_a_out, pad_in);
    chk("R6 bus B unchanged by A write", bus_b_out, exp_in(sh[W_BLO], sh[W_BHI]));
  endtask

  task automatic t_sync();
    logic [31:0] d;
    pad_in = 32'h0F0F_0F0F;
    repeat (3) @(negedge clk);
    pad_in = 32'hF0F0_F0F0;
    @(negedge clk);
    chk("R7 one edge still old", bus_a_out, 32'h0F0F_0F0F);
    @(negedge clk);
    chk("R7 two edges new", bus_a_out, 32'hF0F0_F0F0);
    rd(0, W_PAD, d);
    chk("R7 pad state word", d, 32'hF0F0_F0F0);
  endtask

  task automatic t_pullup();
    wr(0, W_PULL, 32'h8000_0001); #1;
    chk("R8 pullup pattern 1", pullup_en, 32'h8000_0001);
    wr(0, W_PULL, 32'h7FFF_FFFE); #1;
    chk("R8 pullup pattern 2", pullup_en, 32'h7FFF_FFFE);
  endtask

  task automatic t_rmw();
    logic [31:0] d;
    wr(0, W_OLO, 32'hFFFF_0000);
    rd(0, W_OLO, d);
    chk("R9 full readback", d, 32'hFFFF_0000);
    d = (d & ~(32'h3 << 10)) | (32'h2 << 10);
    wr(0, W_OLO, d);
    rd(0, W_OLO, d);
    chk("R9 rmw one field", d, 32'hFFFF_0800);
    rd(0, W_PULL, d);
    chk("R9 other word untouched", d, 32'h7FFF_FFFE);
    wr(1, W_PULL, 32'h0);
    rd(0, W_PULL, d);
    chk("R9 foreign port write ignored", d, 32'h7FFF_FFFE);
    rd(1, W_PULL, d);
    chk("R9 foreign port reads 0", d, 32'h0);
    wr(0, 11, 32'hFFFF_FFFF);
    rd(0, 11, d);
    chk("R9 unmapped word reads 0", d, 32'h0);
    wr(0, W_PAD, 32'h0);
    rd(0, W_PAD, d);
    chk("R9 pad word write ignored", d, pad_in);
    #1 chk("R9 pads unchanged by ignored writes", pad_out, exp_pad());
  endtask

  task automatic t_timing();
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = adr(0, W_PULL); bus_wdata = 32'h0000_A5A5;
    #1 chk("R10 no change before edge", pullup_en, 32'h7FFF_FFFE);
    @(posedge clk); #1;
    chk("R10 change after edge", pullup_en, 32'h0000_A5A5);
    @(negedge clk);
    bus_sel = 0; bus_we = 1; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_we = 0;
    chk("R10 strobe low ignored", pullup_en, 32'h0000_A5A5);
  endtask

  initial begin
    for (int i = 0; i < 11; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_primary();
    t_alt();
    t_outcfg();
    t_incfg();
    t_sync();
    t_pullup();
    t_rmw();
    t_timing();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule